// File: doc/BRIEF.md
# Selective-Reset Control Register Bank

This block holds the 16-bit host-visible registers of a flash-style device controller. A word-addressed synchronous bus reads and writes them. Reads are combinational from the current address. Writes are taken on the rising clock edge.

Four reset sources act on the bank, and each field has its own rule for which of them restore it:
- a power-up (cold) reset input;
- an external pin (warm) reset input;
- a software reset command written to the command word (hot);
- an array-only reset command (core).

A command-reset takes effect on the clock edge after the write that requests it. When several sources are active in the same cycle, the one with the widest scope is applied.

Some registers are fixed identification words. The ECC status and per-sector result words are loaded by an external ECC engine, and the host can only read them. These ECC words are also zeroed by every accepted command write. The interrupt status word is set by event inputs and cleared by the host writing ones to it.

Top module: `mrst_regbank`

## Requirements
- R1: Addresses F000h..F006h return the identification words 00ECh, 0040h, 0011h, 0800h, 0200h, 0201h, 0000h in that order. Writes to them and every reset leave them unchanged.
- R2: Any address outside the map, including F105h and F106h, reads 0000h, and writes to it change no register.
- R3: While `coldRst` is high at a rising edge, the following are loaded:
  - configuration word (F221h) becomes 40C0h;
  - interrupt word (F241h) becomes 8080h;
  - start-address words (F100h..F104h, F107h), start buffer (F200h), command (F220h), block range (F24Ch, F24Dh) and the nine ECC words (FF00h..FF08h) become 0000h.
- R4: A warm reset clears the same words to 0000h as R3 and sets the interrupt word to 8010h. In the configuration word, bits 7:5 (polarities and output enable) and bits 1:0 (lock bits) keep their value, and all other bits take their value from 40C0h.
- R5: A write of 00F3h to F220h, or of 00F0h while `bootCtx` is high, causes a hot reset at the next rising edge. It acts as R4, except that the interrupt word becomes 8030h.
- R6: A write of 00F0h to F220h while `bootCtx` is low causes a core reset at the next rising edge. It sets the command word and all ECC words to 0000h and the interrupt word to 8000h. The start-address, start buffer, configuration and block range words are left unchanged.
- R7: Priority is cold, then warm, then hot, then core. In a cycle where any reset applies, bus writes, ECC loads and interrupt sets are ignored, and a command write is not accepted.
- R8: An accepted command write stores its data in F220h and zeroes FF00h..FF08h at the same edge. This overrides an ECC load in that cycle.
- R9: With `eccLoad` high, `eccData` is stored in ECC word `eccIdx` (0..8 map to FF00h..FF08h; larger indices do nothing). Host writes to the ECC words are ignored.
- R10: At each edge without a reset, the interrupt word becomes (old AND NOT w1c) OR `intSet`. Here w1c is the write data of a host write to F241h, and 0 otherwise. A set therefore wins over a clear of the same bit.
- R11: Host writes to the configuration word can set lock bits 1:0 but never clear them. Only a cold reset clears them.
- R12: `cmdStrobe` is high exactly in a cycle where a write to F220h is accepted.
- R13: F240h reads the `ctrlStatus` input. The remaining writable words (F100h..F104h, F107h, F200h, F24Ch, F24Dh) read back the last data written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| coldRst | input | 1 | Power-up reset, synchronous, active high |
| warmRst | input | 1 | Pin reset, synchronous, active high |
| bootCtx | input | 1 | Turns command 00F0h into a hot reset |
| busAddr | input | 16 | Word address |
| busWrEn | input | 1 | Write enable |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr |
| cmdStrobe | output | 1 | Command write accepted this cycle |
| ctrlStatus | input | 16 | Controller status word read at F240h |
| intSet | input | 16 | Interrupt bits to set |
| eccLoad | input | 1 | ECC engine result write enable |
| eccIdx | input | 4 | ECC word index |
| eccData | input | 16 | ECC result value |

## Verification
The properties assume the following about the inputs:
- both reset inputs are sampled only at the rising edge;
- bus, ECC and interrupt inputs are stable around that edge;
- a cold reset is asserted from time zero.

The bench satisfies these assumptions as follows:
- it changes every input only on the falling edge;
- it holds `coldRst` high through the first edges;
- it issues warm and cold resets and command writes randomly but always as whole-cycle pulses.

Some random cycles use ECC indices above 8, to confirm that the assumed index range is not needed for correctness.

// File: rtl/mrst_pkg.sv
`timescale 1ns/1ps
package mrst_pkg;
  localparam int DW = 16;
  localparam int ID_WORDS = 7;
  localparam int SA_SLOTS = 8;
  localparam int ECC_WORDS = 9;
  localparam int ECC_IDX_W = $clog2(ECC_WORDS);

  localparam logic [SA_SLOTS-1:0] SA_MAP = 8'b1001_1111;

  localparam logic [15:0] A_BUF  = 16'hF200;
  localparam logic [15:0] A_CMD  = 16'hF220;
  localparam logic [15:0] A_CFG  = 16'hF221;
  localparam logic [15:0] A_CST  = 16'hF240;
  localparam logic [15:0] A_INT  = 16'hF241;
  localparam logic [15:0] A_BLKS = 16'hF24C;
  localparam logic [15:0] A_BLKE = 16'hF24D;

  localparam logic [15:0] CMD_HOT   = 16'h00F3;
  localparam logic [15:0] CMD_ARRAY = 16'h00F0;

  localparam logic [15:0] CFG_DEFAULT   = 16'h40C0;
  localparam logic [15:0] CFG_COLD_ONLY = 16'h00E0;
  localparam logic [15:0] CFG_LOCK      = 16'h0003;

  localparam logic [15:0] INT_DEF_COLD = 16'h8080;
  localparam logic [15:0] INT_DEF_WARM = 16'h8010;
  localparam logic [15:0] INT_DEF_HOT  = 16'h8030;
  localparam logic [15:0] INT_DEF_CORE = 16'h8000;

  typedef enum logic [2:0] {RK_NONE, RK_CORE, RK_HOT, RK_WARM, RK_COLD} rst_kind_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_SA, SEL_BUF, SEL_CMD, SEL_CFG,
    SEL_CST, SEL_INT, SEL_BLKS, SEL_BLKE, SEL_ECC
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [3:0] idx;
  } addr_dec_t;

  typedef struct packed {
    rst_kind_e  kind;
    logic       wrEn;
    reg_sel_e   sel;
    logic [3:0] idx;
    logic       cmdWr;
  } bank_ctl_t;

  function automatic addr_dec_t decodeAddr(input logic [15:0] a);
    addr_dec_t d;
    d.sel = SEL_NONE;
    d.idx = a[3:0];
    if (a[15:4] == 12'hF00 && a[3:0] < 4'(ID_WORDS))       d.sel = SEL_ID;
    else if (a[15:3] == 13'h1E20 && SA_MAP[a[2:0]])        d.sel = SEL_SA;
    else if (a == A_BUF)                                   d.sel = SEL_BUF;
    else if (a == A_CMD)                                   d.sel = SEL_CMD;
    else if (a == A_CFG)                                   d.sel = SEL_CFG;
    else if (a == A_CST)                                   d.sel = SEL_CST;
    else if (a == A_INT)                                   d.sel = SEL_INT;
    else if (a == A_BLKS)                                  d.sel = SEL_BLKS;
    else if (a == A_BLKE)                                  d.sel = SEL_BLKE;
    else if (a[15:4] == 12'hFF0 && a[3:0] < 4'(ECC_WORDS)) d.sel = SEL_ECC;
    return d;
  endfunction
endpackage

// File: rtl/mrst_ctrl.sv
`timescale 1ns/1ps
module mrst_ctrl
  import mrst_pkg::*;
(
  input  logic        clk,
  input  logic        coldRst,
  input  logic        warmRst,
  input  logic        bootCtx,
  input  logic [15:0] busAddr,
  input  logic        busWrEn,
  input  logic [15:0] busWrData,
  output bank_ctl_t   ctl,
  output logic        cmdStrobe
);
  logic      hotPend;
  logic      corePend;
  rst_kind_e kind;
  addr_dec_t dec;
  logic      cmdWr;

  // widest-scope source wins
  always_comb begin
    if (coldRst)       kind = RK_COLD;
    else if (warmRst)  kind = RK_WARM;
    else if (hotPend)  kind = RK_HOT;
    else if (corePend) kind = RK_CORE;
    else               kind = RK_NONE;
  end

  assign dec   = decodeAddr(busAddr);
  assign cmdWr = (kind == RK_NONE) && busWrEn && (dec.sel == SEL_CMD);

  // command-requested resets act one edge after the accepted write
  always_ff @(posedge clk) begin
    if (coldRst || warmRst) begin
      hotPend  <= 1'b0;
      corePend <= 1'b0;
    end else begin
      hotPend  <= cmdWr && ((busWrData == CMD_HOT) ||
                            (bootCtx && busWrData == CMD_ARRAY));
      corePend <= cmdWr && !bootCtx && (busWrData == CMD_ARRAY);
    end
  end

  always_comb begin
    ctl.kind  = kind;
    ctl.wrEn  = (kind == RK_NONE) && busWrEn;
    ctl.sel   = dec.sel;
    ctl.idx   = dec.idx;
    ctl.cmdWr = cmdWr;
  end

  assign cmdStrobe = cmdWr;
endmodule

// File: rtl/mrst_datapath.sv
`timescale 1ns/1ps
module mrst_datapath
  import mrst_pkg::*;
#(
  parameter logic [ID_WORDS*DW-1:0] ID_TABLE = '0,
  parameter logic [DW-1:0] CFG_DEF   = CFG_DEFAULT,
  parameter logic [DW-1:0] CFG_STICK = CFG_COLD_ONLY,
  parameter logic [DW-1:0] CFG_LOCKS = CFG_LOCK,
  parameter logic [DW-1:0] INT_COLD  = INT_DEF_COLD,
  parameter logic [DW-1:0] INT_WARM  = INT_DEF_WARM,
  parameter logic [DW-1:0] INT_HOT   = INT_DEF_HOT,
  parameter logic [DW-1:0] INT_CORE  = INT_DEF_CORE
) (
  input  logic                 clk,
  input  bank_ctl_t            ctl,
  input  logic [DW-1:0]        busWrData,
  input  logic [DW-1:0]        ctrlStatus,
  input  logic [DW-1:0]        intSet,
  input  logic                 eccLoad,
  input  logic [ECC_IDX_W-1:0] eccIdx,
  input  logic [DW-1:0]        eccData,
  output logic [DW-1:0]        busRdData
);
  localparam logic [DW-1:0] CFG_KEEP = CFG_STICK | CFG_LOCKS;

  logic broadRst;
  logic anyRst;
  assign broadRst = (ctl.kind == RK_HOT) || (ctl.kind == RK_WARM) || (ctl.kind == RK_COLD);
  assign anyRst   = (ctl.kind != RK_NONE);

  function automatic logic hit(input bank_ctl_t c, input reg_sel_e s);
    return c.wrEn && (c.sel == s);
  endfunction

  logic [DW-1:0] saQ [SA_SLOTS];
  logic [DW-1:0] eccQ [ECC_WORDS];
  logic [DW-1:0] bufQ, cmdQ, cfgQ, intQ, blkSQ, blkEQ;

  for (genvar g = 0; g < SA_SLOTS; g++) begin : g_sa
    if (SA_MAP[g]) begin : g_live
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (broadRst)
          q <= '0;
        else if (hit(ctl, SEL_SA) && ctl.idx == 4'(g))
          q <= busWrData;
      end
      assign saQ[g] = q;
    end else begin : g_gap
      assign saQ[g] = '0;
    end
  end

  for (genvar g = 0; g < ECC_WORDS; g++) begin : g_ecc
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (anyRst || ctl.cmdWr)
        q <= '0;
      else if (eccLoad && eccIdx == ECC_IDX_W'(g))
        q <= eccData;
    end
    assign eccQ[g] = q;
  end

  always_ff @(posedge clk) begin
    if (broadRst) begin
      bufQ  <= '0;
      blkSQ <= '0;
      blkEQ <= '0;
    end else begin
      if (hit(ctl, SEL_BUF))  bufQ  <= busWrData;
      if (hit(ctl, SEL_BLKS)) blkSQ <= busWrData;
      if (hit(ctl, SEL_BLKE)) blkEQ <= busWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (anyRst)         cmdQ <= '0;
    else if (ctl.cmdWr) cmdQ <= busWrData;
  end

  always_ff @(posedge clk) begin
    unique case (ctl.kind)
      RK_COLD:         cfgQ <= CFG_DEF;
      RK_WARM, RK_HOT: cfgQ <= (cfgQ & CFG_KEEP) | (CFG_DEF & ~CFG_KEEP);
      RK_CORE:         cfgQ <= cfgQ;
      default: begin
        if (hit(ctl, SEL_CFG))
          cfgQ <= (busWrData & ~CFG_LOCKS) | ((busWrData | cfgQ) & CFG_LOCKS);
      end
    endcase
  end

  logic [DW-1:0] w1cMask;
  assign w1cMask = hit(ctl, SEL_INT) ? busWrData : '0;

  always_ff @(posedge clk) begin
    unique case (ctl.kind)
      RK_COLD: intQ <= INT_COLD;
      RK_WARM: intQ <= INT_WARM;
      RK_HOT:  intQ <= INT_HOT;
      RK_CORE: intQ <= INT_CORE;
      default: intQ <= (intQ & ~w1cMask) | intSet;
    endcase
  end

  always_comb begin
    busRdData = '0;
    unique case (ctl.sel)
      SEL_ID:
        for (int i = 0; i < ID_WORDS; i++)
          if (ctl.idx == 4'(i)) busRdData = ID_TABLE[i*DW +: DW];
      SEL_SA:
        for (int i = 0; i < SA_SLOTS; i++)
          if (ctl.idx == 4'(i)) busRdData = saQ[i];
      SEL_ECC:
        for (int i = 0; i < ECC_WORDS; i++)
          if (ctl.idx == 4'(i)) busRdData = eccQ[i];
      SEL_BUF:  busRdData = bufQ;
      SEL_CMD:  busRdData = cmdQ;
      SEL_CFG:  busRdData = cfgQ;
      SEL_CST:  busRdData = ctrlStatus;
      SEL_INT:  busRdData = intQ;
      SEL_BLKS: busRdData = blkSQ;
      SEL_BLKE: busRdData = blkEQ;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/mrst_regbank.sv
`timescale 1ns/1ps
module mrst_regbank
  import mrst_pkg::*;
#(
  parameter logic [ID_WORDS*DW-1:0] ID_TABLE =
    {16'h0000, 16'h0201, 16'h0200, 16'h0800, 16'h0011, 16'h0040, 16'h00EC},
  parameter logic [DW-1:0] CFG_DEF  = CFG_DEFAULT,
  parameter logic [DW-1:0] INT_COLD = INT_DEF_COLD,
  parameter logic [DW-1:0] INT_WARM = INT_DEF_WARM,
  parameter logic [DW-1:0] INT_HOT  = INT_DEF_HOT,
  parameter logic [DW-1:0] INT_CORE = INT_DEF_CORE
) (
  input  logic                 clk,
  input  logic                 coldRst,
  input  logic                 warmRst,
  input  logic                 bootCtx,
  input  logic [15:0]          busAddr,
  input  logic                 busWrEn,
  input  logic [15:0]          busWrData,
  output logic [15:0]          busRdData,
  output logic                 cmdStrobe,
  input  logic [15:0]          ctrlStatus,
  input  logic [15:0]          intSet,
  input  logic                 eccLoad,
  input  logic [ECC_IDX_W-1:0] eccIdx,
  input  logic [15:0]          eccData
);
  bank_ctl_t ctl;

  mrst_ctrl u_ctrl (
    .clk       (clk),
    .coldRst   (coldRst),
    .warmRst   (warmRst),
    .bootCtx   (bootCtx),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .ctl       (ctl),
    .cmdStrobe (cmdStrobe)
  );

  mrst_datapath #(
    .ID_TABLE  (ID_TABLE),
    .CFG_DEF   (CFG_DEF),
    .CFG_STICK (CFG_COLD_ONLY),
    .CFG_LOCKS (CFG_LOCK),
    .INT_COLD  (INT_COLD),
    .INT_WARM  (INT_WARM),
    .INT_HOT   (INT_HOT),
    .INT_CORE  (INT_CORE)
  ) u_dp (
    .clk        (clk),
    .ctl        (ctl),
    .busWrData  (busWrData),
    .ctrlStatus (ctrlStatus),
    .intSet     (intSet),
    .eccLoad    (eccLoad),
    .eccIdx     (eccIdx),
    .eccData    (eccData),
    .busRdData  (busRdData)
  );
endmodule

// File: rtl/mrst_regbank_chk.sv
`timescale 1ns/1ps
module mrst_regbank_chk
  import mrst_pkg::*;
(
  input logic        clk,
  input logic        coldRst,
  input logic        warmRst,
  input logic [15:0] busAddr,
  input logic        busWrEn,
  input logic [15:0] busWrData,
  input logic [15:0] busRdData,
  input logic        cmdStrobe,
  input logic [15:0] intSet,
  input bank_ctl_t   ctl
);
  logic eccAddr;
  assign eccAddr = (busAddr[15:4] == 12'hFF0) && (busAddr[3:0] < 4'(ECC_WORDS));

  p_id_stable_r1: assert property (@(posedge clk) disable iff (coldRst)
    (busAddr == 16'hF000 && $past(busAddr) == 16'hF000) |-> $stable(busRdData));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (coldRst)
    (busAddr == 16'hF105) |-> (busRdData == 16'h0000));

  p_warm_clears_cmd_r4: assert property (@(posedge clk) disable iff (coldRst)
    warmRst |=> ((busAddr == A_CMD) -> (busRdData == 16'h0000)));

  p_hot_int_default_r5: assert property (@(posedge clk) disable iff (coldRst || warmRst)
    (ctl.kind == RK_HOT) |=> ((busAddr == A_INT) -> (busRdData == INT_DEF_HOT)));

  p_reset_blocks_cmd_r7: assert property (@(posedge clk) disable iff (coldRst)
    warmRst |-> !cmdStrobe);

  p_cmd_clears_ecc_r8: assert property (@(posedge clk) disable iff (coldRst || warmRst)
    ctl.cmdWr |=> (eccAddr -> (busRdData == 16'h0000)));

  p_w1c_r10: assert property (@(posedge clk) disable iff (coldRst || warmRst)
    (busWrEn && busAddr == A_INT && ctl.kind == RK_NONE && intSet == 16'h0000)
    |=> ((busAddr == A_INT) -> ((busRdData & $past(busWrData)) == 16'h0000)));
endmodule

bind mrst_regbank mrst_regbank_chk u_chk (
  .clk       (clk),
  .coldRst   (coldRst),
  .warmRst   (warmRst),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .cmdStrobe (cmdStrobe),
  .intSet    (intSet),
  .ctl       (ctl)
);

// File: tb/mrst_regbank_test.sv
`timescale 1ns/1ps
module mrst_regbank_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        coldRst = 1'b1, warmRst = 1'b0, bootCtx = 1'b0;
  logic        busWrEn = 1'b0, eccLoad = 1'b0;
  logic [15:0] busAddr = '0, busWrData = '0, ctrlStatus = '0, intSet = '0, eccData = '0;
  logic [3:0]  eccIdx = '0;
  logic [15:0] busRdData;
  logic        cmdStrobe;

  mrst_regbank uut (
    .clk(clk), .coldRst(coldRst), .warmRst(warmRst), .bootCtx(bootCtx),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .cmdStrobe(cmdStrobe), .ctrlStatus(ctrlStatus),
    .intSet(intSet), .eccLoad(eccLoad), .eccIdx(eccIdx), .eccData(eccData)
  );

  // behavioural reference state
  logic [15:0] mSa [8];
  logic [15:0] mEcc [9];
  logic [15:0] mBuf, mCmd, mCfg, mInt, mBlkS, mBlkE;
  bit mHot = 0, mCore = 0, armed = 0, finished = 0;
  int checks = 0, errors = 0;
  logic [15:0] idVal [7] = '{16'h00EC, 16'h0040, 16'h0011, 16'h0800, 16'h0200, 16'h0201, 16'h0000};
  logic [15:0] sweepList [30] = '{
    16'hF000, 16'hF001, 16'hF002, 16'hF003, 16'hF004, 16'hF005, 16'hF006,
    16'hF100, 16'hF101, 16'hF102, 16'hF103, 16'hF104, 16'hF105, 16'hF106, 16'hF107,
    16'hF200, 16'hF220, 16'hF221, 16'hF240, 16'hF241, 16'hF24C, 16'hF24D,
    16'hFF00, 16'hFF01, 16'hFF02, 16'hFF03, 16'hFF04, 16'hFF05, 16'hFF08, 16'h1234};

  function automatic logic [15:0] mRead(input logic [15:0] a);
    if (a >= 16'hF000 && a <= 16'hF006) return idVal[int'(a - 16'hF000)];
    if (a >= 16'hF100 && a <= 16'hF107 && a != 16'hF105 && a != 16'hF106) return mSa[a[2:0]];
    if (a >= 16'hFF00 && a <= 16'hFF08) return mEcc[a[3:0]];
    case (a)
      16'hF200: return mBuf;
      16'hF220: return mCmd;
      16'hF221: return mCfg;
      16'hF240: return ctrlStatus;
      16'hF241: return mInt;
      16'hF24C: return mBlkS;
      16'hF24D: return mBlkE;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string reqFor(input logic [15:0] a);
    if (a >= 16'hF000 && a <= 16'hF006) return "R1";
    if (a >= 16'hFF00 && a <= 16'hFF08) return "R8";
    case (a)
      16'hF220: return "R5";
      16'hF221: return "R11";
      16'hF241: return "R10";
      16'hF100, 16'hF101, 16'hF102, 16'hF103, 16'hF104, 16'hF107,
      16'hF200, 16'hF240, 16'hF24C, 16'hF24D: return "R13";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h at %0t", req, busAddr, act, exp, $time);
    end
  endtask

  task automatic mStep(input int k, input bit cw);
    logic [15:0] clr;
    clr = 16'h0000;
    if (k >= 2) begin
      foreach (mSa[i]) mSa[i] = 16'h0000;
      foreach (mEcc[i]) mEcc[i] = 16'h0000;
      mBuf = 0; mBlkS = 0; mBlkE = 0; mCmd = 0;
      mCfg = (k == 4) ? 16'h40C0 : ((mCfg & 16'h00E3) | 16'h4000);
      mInt = (k == 4) ? 16'h8080 : (k == 3) ? 16'h8010 : 16'h8030;
      mHot = 0; mCore = 0;
    end else if (k == 1) begin
      foreach (mEcc[i]) mEcc[i] = 16'h0000;
      mCmd = 0; mInt = 16'h8000; mHot = 0; mCore = 0;
    end else begin
      if (busWrEn) begin
        if (busAddr inside {16'hF100, 16'hF101, 16'hF102, 16'hF103, 16'hF104, 16'hF107})
          mSa[busAddr[2:0]] = busWrData;
        case (busAddr)
          16'hF200: mBuf = busWrData;
          16'hF220: mCmd = busWrData;
          16'hF221: mCfg = (busWrData & 16'hFFFC) | ((busWrData | mCfg) & 16'h0003);
          16'hF241: clr = busWrData;
          16'hF24C: mBlkS = busWrData;
          16'hF24D: mBlkE = busWrData;
          default: ;
        endcase
      end
      mInt = (mInt & ~clr) | intSet;
      if (cw) foreach (mEcc[i]) mEcc[i] = 16'h0000;
      else if (eccLoad && eccIdx < 4'd9) mEcc[eccIdx] = eccData;
      mHot  = cw && (busWrData == 16'h00F3 || (bootCtx && busWrData == 16'h00F0));
      mCore = cw && !bootCtx && busWrData == 16'h00F0;
    end
  endtask

  task automatic tick();
    int k;
    bit cw;
    k  = coldRst ? 4 : warmRst ? 3 : mHot ? 2 : mCore ? 1 : 0;
    cw = (k == 0) && busWrEn && busAddr == 16'hF220;
    #1;
    if (armed) begin
      check(busRdData, mRead(busAddr), reqFor(busAddr));
      check({15'b0, cmdStrobe}, {15'b0, cw}, "R12");
    end
    mStep(k, cw);
    armed = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic expectAt(input logic [15:0] a, input logic [15:0] e, input string req);
    busAddr = a; busWrEn = 1'b0;
    #1 check(busRdData, e, req);
    tick();
  endtask

  task automatic sweep();
    foreach (sweepList[i]) begin
      busAddr = sweepList[i];
      tick();
    end
  endtask

  task automatic fillRegs(input logic [15:0] base);
    wr(16'hF100, base ^ 16'h1111); wr(16'hF101, base ^ 16'h2222);
    wr(16'hF102, base ^ 16'h3333); wr(16'hF103, base ^ 16'h4444);
    wr(16'hF104, base ^ 16'h5555); wr(16'hF107, base ^ 16'h6666);
    wr(16'hF200, base ^ 16'h7777); wr(16'hF24C, base ^ 16'h0101);
    wr(16'hF24D, base ^ 16'h0202);
    for (int i = 0; i < 9; i++) begin
      eccLoad = 1'b1; eccIdx = 4'(i); eccData = base + 16'(i);
      tick();
    end
    eccLoad = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog expired");
      finish();
    end
  end

  initial begin
    foreach (mSa[i]) mSa[i] = 0;
    foreach (mEcc[i]) mEcc[i] = 0;
    mBuf = 0; mCmd = 0; mCfg = 0; mInt = 0; mBlkS = 0; mBlkE = 0;
    @(negedge clk);
    tick(); tick();
    coldRst = 1'b0;
    // R3 cold defaults, R1 identification
    expectAt(16'hF221, 16'h40C0, "R3");
    expectAt(16'hF241, 16'h8080, "R3");
    expectAt(16'hF100, 16'h0000, "R3");
    expectAt(16'hF000, 16'h00EC, "R1");
    sweep();

    fillRegs(16'hA500);
    ctrlStatus = 16'h5A3C;
    expectAt(16'hF240, 16'h5A3C, "R13");
    expectAt(16'hF107, 16'hA500 ^ 16'h6666, "R13");
    expectAt(16'hFF03, 16'hA503, "R9");
    wr(16'hFF03, 16'hDEAD);
    expectAt(16'hFF03, 16'hA503, "R9");
    // R1/R2 read-only and unmapped writes ignored
    wr(16'hF000, 16'hFFFF);
    expectAt(16'hF000, 16'h00EC, "R1");
    wr(16'hF105, 16'hBEEF);
    expectAt(16'hF105, 16'h0000, "R2");
    expectAt(16'h1234, 16'h0000, "R2");
    // R11 lock bits sticky
    wr(16'hF221, 16'h00FF);
    wr(16'hF221, 16'h0020);
    expectAt(16'hF221, 16'h0023, "R11");
    sweep();

    // R4 warm reset
    warmRst = 1'b1; tick(); warmRst = 1'b0;
    expectAt(16'hF221, 16'h4023, "R4");
    expectAt(16'hF241, 16'h8010, "R4");
    expectAt(16'hF100, 16'h0000, "R4");
    sweep();

    // R8 command clears ECC, R12 strobe
    fillRegs(16'h3C00);
    wr(16'hF220, 16'h0012);
    expectAt(16'hF220, 16'h0012, "R8");
    expectAt(16'hFF00, 16'h0000, "R8");
    eccLoad = 1'b1; eccIdx = 4'd2; eccData = 16'h5555;
    wr(16'hF220, 16'h0013);
    eccLoad = 1'b0;
    expectAt(16'hFF02, 16'h0000, "R8");

    // R5 hot reset by command
    fillRegs(16'h1200);
    wr(16'hF221, 16'h00A0);
    wr(16'hF220, 16'h00F3);
    busAddr = 16'hF100; tick();
    expectAt(16'hF220, 16'h0000, "R5");
    expectAt(16'hF221, 16'h40A3, "R5");
    expectAt(16'hF241, 16'h8030, "R5");
    expectAt(16'hF104, 16'h0000, "R5");
    sweep();

    // R6 core reset keeps host configuration
    fillRegs(16'h4400);
    wr(16'hF221, 16'h0040);
    bootCtx = 1'b0;
    wr(16'hF220, 16'h00F0);
    tick();
    expectAt(16'hF100, 16'h4400 ^ 16'h1111, "R6");
    expectAt(16'hF221, 16'h0043, "R6");
    expectAt(16'hF241, 16'h8000, "R6");
    expectAt(16'hF220, 16'h0000, "R6");
    expectAt(16'hFF05, 16'h0000, "R6");
    sweep();

    // R5 boot-context array code acts as hot reset
    bootCtx = 1'b1;
    wr(16'hF220, 16'h00F0);
    tick();
    bootCtx = 1'b0;
    expectAt(16'hF100, 16'h0000, "R5");
    expectAt(16'hF241, 16'h8030, "R5");

    // R10 write-one-to-clear, set wins
    intSet = 16'h0006; tick(); intSet = 16'h0000;
    expectAt(16'hF241, 16'h8036, "R10");
    intSet = 16'h0002;
    wr(16'hF241, 16'h8006);
    intSet = 16'h0000;
    expectAt(16'hF241, 16'h0032, "R10");

    // R7 priorities and writes ignored during resets
    fillRegs(16'h7700);
    wr(16'hF220, 16'h00F3);
    warmRst = 1'b1; tick(); warmRst = 1'b0;
    expectAt(16'hF241, 16'h8010, "R7");
    warmRst = 1'b1; coldRst = 1'b1; tick(); warmRst = 1'b0; coldRst = 1'b0;
    expectAt(16'hF241, 16'h8080, "R7");
    warmRst = 1'b1;
    wr(16'hF100, 16'h9999);
    warmRst = 1'b0;
    expectAt(16'hF100, 16'h0000, "R7");
    wr(16'hF220, 16'h00F0);
    wr(16'hF101, 16'h7777);
    expectAt(16'hF101, 16'h0000, "R7");

    // mixed random traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      busAddr   = sweepList[$urandom_range(0, 29)];
      busWrEn   = (r < 35);
      busWrData = 16'($urandom);
      if (r < 6) begin busAddr = 16'hF220; busWrData = (r < 3) ? 16'h00F3 : 16'h00F0; end
      bootCtx    = ($urandom_range(0, 3) == 0);
      warmRst    = ($urandom_range(0, 99) < 2);
      coldRst    = ($urandom_range(0, 199) == 0);
      intSet     = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'h0000;
      eccLoad    = ($urandom_range(0, 3) == 0);
      eccIdx     = 4'($urandom);
      eccData    = 16'($urandom);
      ctrlStatus = 16'($urandom);
      tick();
    end
    busWrEn = 0; warmRst = 0; coldRst = 0; eccLoad = 0; intSet = 0;
    sweep();
    finish();
  end
endmodule